// File: doc/BRIEF.md
# Hard and Soft Reset Sequencer

This block runs the hard and soft reset sequences of a processor subsystem on the bus clock. Each reset line is open-drain and active-low. The block pulls a line low through a drive enable and also reads the line back. A hard reset can come from three places: a watchdog expiry, a bus-monitor timeout, or another device pulling the hard line low. During a hard reset the block holds both lines low. A soft reset can come from a test-mode request (a boundary-scan instruction that takes over the pins) or from another device pulling the soft line low. During a soft reset the block holds only the soft line low.

After the fixed assertion interval the block releases its drives. It then waits until both lines read high again, since an external pull-up has to raise them. After that it counts a blanking window before it accepts a low line as a new request. Two internal strobes follow the sequence. A configuration-word latch accepts writes only from power-on until the first hard reset starts. From then on it keeps its value, and soft resets never touch it.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, both drive enables, both strobes and `done_o` are 0 and `cfg_word_o` equals parameter `CFG_RST`.
- R2: In the idle state, a hard reset starts on the next clock edge when any of these holds: `wdog_expire_i` is 1, `busmon_expire_i` is 1, or the hard line has read 0 through the two-flop synchronizer.
- R3: A hard reset sets `hard_drive_o`, `soft_drive_o`, `hard_rst_o` and `soft_rst_o` to 1 for exactly 512 consecutive cycles and then clears them together.
- R4: A soft reset starts from idle when `test_req_i` is 1 or when the synchronized soft line reads 0. It then sets only `soft_drive_o` and `soft_rst_o` to 1 for 512 cycles, and `hard_drive_o` and `hard_rst_o` stay 0.
- R5: A hard request during a soft assertion turns the sequence into a hard reset. That hard reset lasts a full 512 cycles counted from the upgrade.
- R6: Requests that arrive during a hard assertion, during the release wait or during blanking have no effect. A hard or soft request that arrives while no hard request is present in a soft assertion has no effect either.
- R7: After the drives are released, blanking starts only once both synchronized lines read 1. An external low that is held longer than the assertion therefore extends the wait.
- R8: Blanking lasts 16 cycles. `done_o` is 1 for exactly one cycle, the last cycle of blanking, and the block is idle on the next cycle.
- R9: The sensed level of each line is the pad level ANDed with the inverse of the block's own drive enable. The block's own drive therefore shows up as a low line.
- R10: `cfg_wr_i` loads `cfg_data_i` into `cfg_word_o` only from reset until the edge on which the first hard reset starts. Writes on that edge are still taken. Later writes are dropped, and soft resets leave the word as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| hard_pad_i | input | 1 | Level on the hard line from outside (1 = pull-up, 0 = pulled low) |
| soft_pad_i | input | 1 | Level on the soft line from outside |
| wdog_expire_i | input | 1 | Watchdog expiry request |
| busmon_expire_i | input | 1 | Bus-monitor timeout request |
| test_req_i | input | 1 | Test-mode soft reset request |
| cfg_wr_i | input | 1 | Configuration word write strobe |
| cfg_data_i | input | CFG_W | Configuration word write data |
| hard_drive_o | output | 1 | Pull-down enable for the hard line |
| soft_drive_o | output | 1 | Pull-down enable for the soft line |
| hard_rst_o | output | 1 | Internal hard reset strobe |
| soft_rst_o | output | 1 | Internal soft reset strobe |
| done_o | output | 1 | One-cycle pulse on the last blanking cycle |
| cfg_word_o | output | CFG_W | Latched configuration word |

## Verification
The assertions assume that request inputs are synchronous to the bus clock. They also assume that an external low on a line is eventually released, so every sequence reaches its done pulse and the run-length counters reset. The bench drives all inputs on the falling edge. It holds pad lows only for bounded stretches, including one that outlasts the assertion interval, and it times later sequences so they start only after the previous one has finished.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_HARD  = 3'd1,
    SEQ_SOFT  = 3'd2,
    SEQ_WREL  = 3'd3,
    SEQ_BLANK = 3'd4
  } seq_state_e;

  localparam int unsigned SYNC_STAGES_DEF = 2;

endpackage

// File: rtl/rst_line_sync.sv
// Multi-bit synchronizer chain for sensed reset line levels; resets to the idle (high) level.
module rst_line_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        chain_q[i] <= {WIDTH{RST_VAL}};
      end
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rst_seq_fsm.sv
// Sequence controller: assertion interval, release wait, blanking window.
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int unsigned ASSERT_CYC = 512,
  parameter int unsigned BLANK_CYC  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hard_req_i,
  input  logic soft_req_i,
  input  logic hard_lvl_i,
  input  logic soft_lvl_i,
  output logic hard_act_o,
  output logic soft_act_o,
  output logic hard_go_o,
  output logic done_o
);

  localparam int unsigned MAX_CYC     = (ASSERT_CYC > BLANK_CYC) ? ASSERT_CYC : BLANK_CYC;
  localparam int unsigned CNT_W       = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] ASSERT_LAST = CNT_W'(ASSERT_CYC - 1);
  localparam logic [CNT_W-1:0] BLANK_LAST  = CNT_W'(BLANK_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_ONE     = CNT_W'(1);

  seq_state_e       st_q, st_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             cnt_en;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  // next-state logic
  always_comb begin
    st_nx     = st_q;
    cnt_nx    = cnt_q;
    cnt_en    = 1'b0;
    hard_go_o = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (hard_req_i) begin
          st_nx     = SEQ_HARD;
          cnt_nx    = ASSERT_LAST;
          cnt_en    = 1'b1;
          hard_go_o = 1'b1;
        end else if (soft_req_i) begin
          st_nx  = SEQ_SOFT;
          cnt_nx = ASSERT_LAST;
          cnt_en = 1'b1;
        end
      end
      SEQ_HARD: begin
        if (cnt_zero) begin
          st_nx = SEQ_WREL;
        end else begin
          cnt_nx = cnt_q - CNT_ONE;
          cnt_en = 1'b1;
        end
      end
      SEQ_SOFT: begin
        if (hard_req_i) begin
          st_nx     = SEQ_HARD;
          cnt_nx    = ASSERT_LAST;
          cnt_en    = 1'b1;
          hard_go_o = 1'b1;
        end else if (cnt_zero) begin
          st_nx = SEQ_WREL;
        end else begin
          cnt_nx = cnt_q - CNT_ONE;
          cnt_en = 1'b1;
        end
      end
      SEQ_WREL: begin
        if (hard_lvl_i && soft_lvl_i) begin
          st_nx  = SEQ_BLANK;
          cnt_nx = BLANK_LAST;
          cnt_en = 1'b1;
        end
      end
      SEQ_BLANK: begin
        if (cnt_zero) begin
          st_nx = SEQ_IDLE;
        end else begin
          cnt_nx = cnt_q - CNT_ONE;
          cnt_en = 1'b1;
        end
      end
      default: begin
        st_nx = SEQ_IDLE;
      end
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SEQ_IDLE;
    end else begin
      st_q <= st_nx;
    end
  end

  // interval counter with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nx;
    end
  end

  assign hard_act_o = (st_q == SEQ_HARD);
  assign soft_act_o = (st_q == SEQ_SOFT);
  assign done_o     = (st_q == SEQ_BLANK) && cnt_zero;

endmodule

// File: rtl/rst_cfg_gate.sv
// Configuration word latch, writable only until the first hard reset begins.
module rst_cfg_gate #(
  parameter int unsigned     CFG_W   = 32,
  parameter logic [CFG_W-1:0] CFG_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hard_go_i,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] wr_data_i,
  output logic [CFG_W-1:0] word_o
);

  logic open_q;
  logic load_en;

  assign load_en = wr_i && open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b1;
    end else if (hard_go_i) begin
      open_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o <= CFG_RST;
    end else if (load_en) begin
      word_o <= wr_data_i;
    end
  end

endmodule

// File: rtl/rst_seq_ctrl.sv
// Top: open-drain line sensing, request combining, sequencing and config gating.
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int unsigned      ASSERT_CYC  = 512,
  parameter int unsigned      BLANK_CYC   = 16,
  parameter int unsigned      SYNC_STAGES = SYNC_STAGES_DEF,
  parameter int unsigned      CFG_W       = 32,
  parameter logic [CFG_W-1:0] CFG_RST     = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hard_pad_i,
  input  logic             soft_pad_i,
  input  logic             wdog_expire_i,
  input  logic             busmon_expire_i,
  input  logic             test_req_i,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_data_i,
  output logic             hard_drive_o,
  output logic             soft_drive_o,
  output logic             hard_rst_o,
  output logic             soft_rst_o,
  output logic             done_o,
  output logic [CFG_W-1:0] cfg_word_o
);

  localparam int unsigned LINES = 2;
  localparam int unsigned L_HARD = 0;
  localparam int unsigned L_SOFT = 1;

  logic [LINES-1:0] sense_raw;
  logic [LINES-1:0] sense_sync;
  logic             hard_act, soft_act, hard_go;
  logic             hard_req, soft_req;

  // wired-AND of pad level with own pull-down
  assign sense_raw[L_HARD] = hard_pad_i & ~hard_drive_o;
  assign sense_raw[L_SOFT] = soft_pad_i & ~soft_drive_o;

  rst_line_sync #(
    .WIDTH   (LINES),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (sense_raw),
    .q_o   (sense_sync)
  );

  assign hard_req = wdog_expire_i | busmon_expire_i | ~sense_sync[L_HARD];
  assign soft_req = test_req_i | ~sense_sync[L_SOFT];

  rst_seq_fsm #(
    .ASSERT_CYC (ASSERT_CYC),
    .BLANK_CYC  (BLANK_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .hard_req_i (hard_req),
    .soft_req_i (soft_req),
    .hard_lvl_i (sense_sync[L_HARD]),
    .soft_lvl_i (sense_sync[L_SOFT]),
    .hard_act_o (hard_act),
    .soft_act_o (soft_act),
    .hard_go_o  (hard_go),
    .done_o     (done_o)
  );

  rst_cfg_gate #(
    .CFG_W   (CFG_W),
    .CFG_RST (CFG_RST)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .hard_go_i (hard_go),
    .wr_i      (cfg_wr_i),
    .wr_data_i (cfg_data_i),
    .word_o    (cfg_word_o)
  );

  assign hard_drive_o = hard_act;
  assign soft_drive_o = hard_act | soft_act;
  assign hard_rst_o   = hard_act;
  assign soft_rst_o   = hard_act | soft_act;

endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk #(
  parameter int unsigned ASSERT_CYC = 512,
  parameter int unsigned CFG_W      = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hard_drive_o,
  input logic             soft_drive_o,
  input logic             hard_rst_o,
  input logic             done_o,
  input logic [CFG_W-1:0] cfg_word_o
);

  localparam int unsigned RUN_W = $clog2(ASSERT_CYC + 1) + 1;

  logic [RUN_W-1:0] hard_run;
  logic [RUN_W-1:0] soft_run;
  logic             cfg_locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hard_run   <= '0;
      soft_run   <= '0;
      cfg_locked <= 1'b0;
    end else begin
      hard_run <= hard_drive_o ? hard_run + 1'b1 : '0;
      soft_run <= (soft_drive_o && !hard_drive_o) ? soft_run + 1'b1 : '0;
      if (hard_rst_o) begin
        cfg_locked <= 1'b1;
      end
    end
  end

  // R3: hard reset pulls both lines
  p_hard_pulls_soft_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hard_drive_o |-> soft_drive_o);

  // R3: a hard run ends after exactly the assertion interval
  p_hard_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hard_drive_o && hard_run != '0) |-> (hard_run == RUN_W'(ASSERT_CYC)));

  // R4: a soft-only run that releases has lasted the full interval
  p_soft_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_drive_o && soft_run != '0) |-> (soft_run == RUN_W'(ASSERT_CYC)));

  // R4: no internal hard strobe during soft-only assertion
  p_soft_no_hard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_drive_o && !hard_drive_o) |-> !hard_rst_o);

  // R8: done is a single-cycle pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: done only with both lines released
  p_done_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!hard_drive_o && !soft_drive_o));

  // R10: word frozen once a hard reset has started
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_locked |=> $stable(cfg_word_o));

endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk #(
  .ASSERT_CYC (ASSERT_CYC),
  .CFG_W      (CFG_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hard_drive_o (hard_drive_o),
  .soft_drive_o (soft_drive_o),
  .hard_rst_o   (hard_rst_o),
  .done_o       (done_o),
  .cfg_word_o   (cfg_word_o)
);

// File: tb/rst_seq_ctrl_test.sv
module rst_seq_ctrl_test;

  localparam int CFG_W = 32;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             hard_pad, soft_pad, wdog, busmon, test_req, cfg_wr;
  logic [CFG_W-1:0] cfg_data;
  logic             hard_drive, soft_drive, hard_rst, soft_rst, done;
  logic [CFG_W-1:0] cfg_word;

  int    vectors = 0;
  int    fails   = 0;
  bit    finished = 0;
  string tag = "R1";

  // reference model state: 0 idle, 1 hard, 2 soft, 3 wait release, 4 blank
  int             m_st;
  int             m_cnt;
  bit             m_h1, m_h2, m_s1, m_s2;
  bit             m_open;
  logic [CFG_W-1:0] m_word;

  always #10 clk = ~clk;

  rst_seq_ctrl uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .hard_pad_i      (hard_pad),
    .soft_pad_i      (soft_pad),
    .wdog_expire_i   (wdog),
    .busmon_expire_i (busmon),
    .test_req_i      (test_req),
    .cfg_wr_i        (cfg_wr),
    .cfg_data_i      (cfg_data),
    .hard_drive_o    (hard_drive),
    .soft_drive_o    (soft_drive),
    .hard_rst_o      (hard_rst),
    .soft_rst_o      (soft_rst),
    .done_o          (done),
    .cfg_word_o      (cfg_word)
  );

  task automatic check(input string what, input logic [CFG_W-1:0] act, input logic [CFG_W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit hd, sd;
    hd = (m_st == 1);
    sd = (m_st == 1) || (m_st == 2);
    check("hard_drive", CFG_W'(hard_drive), CFG_W'(hd));
    check("soft_drive", CFG_W'(soft_drive), CFG_W'(sd));
    check("hard_rst",   CFG_W'(hard_rst),   CFG_W'(hd));
    check("soft_rst",   CFG_W'(soft_rst),   CFG_W'(sd));
    check("done",       CFG_W'(done),       CFG_W'((m_st == 4) && (m_cnt == 0)));
    check("cfg_word",   cfg_word,           m_word);
  endtask

  task automatic model_step();
    bit hd, sd, sh, ss, hreq, sreq, go;
    int nst, ncnt;
    hd   = (m_st == 1);
    sd   = (m_st == 1) || (m_st == 2);
    sh   = hard_pad && !hd;
    ss   = soft_pad && !sd;
    hreq = wdog || busmon || !m_h2;
    sreq = test_req || !m_s2;
    nst  = m_st;
    ncnt = m_cnt;
    go   = 0;
    case (m_st)
      0: if (hreq) begin nst = 1; ncnt = 511; go = 1; end
         else if (sreq) begin nst = 2; ncnt = 511; end
      1: if (m_cnt == 0) nst = 3; else ncnt = m_cnt - 1;
      2: if (hreq) begin nst = 1; ncnt = 511; go = 1; end
         else if (m_cnt == 0) nst = 3; else ncnt = m_cnt - 1;
      3: if (m_h2 && m_s2) begin nst = 4; ncnt = 15; end
      default: if (m_cnt == 0) nst = 0; else ncnt = m_cnt - 1;
    endcase
    if (cfg_wr && m_open) m_word = cfg_data;
    if (go) m_open = 0;
    m_h2 = m_h1; m_h1 = sh;
    m_s2 = m_s1; m_s1 = ss;
    m_st = nst;
    m_cnt = ncnt;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      model_step();
      @(negedge clk);
      compare();
      wdog = 0; busmon = 0; test_req = 0; cfg_wr = 0;
    end
  endtask

  initial begin
    rst_n = 0; hard_pad = 1; soft_pad = 1; wdog = 0; busmon = 0; test_req = 0;
    cfg_wr = 0; cfg_data = '0;
    m_st = 0; m_cnt = 0; m_h1 = 1; m_h2 = 1; m_s1 = 1; m_s2 = 1; m_open = 1; m_word = '0;
    // R1: reset values while reset is held and just after release
    repeat (2) @(negedge clk);
    compare();
    rst_n = 1;
    tick(5);

    // R10: write accepted while the latch is open
    tag = "R10"; cfg_wr = 1; cfg_data = 32'hA5A5_0001; tick(3);

    // R2 R3: watchdog starts a hard reset (R9 own drive reads back low)
    tag = "R3"; wdog = 1; tick(600);

    // R10: hard reset closed the latch, write ignored
    tag = "R10"; cfg_wr = 1; cfg_data = 32'h0000_BEEF; tick(3);

    // R4: test-mode request starts a soft reset
    tag = "R4"; test_req = 1; tick(600);

    // R2: bus-monitor timeout
    tag = "R2"; busmon = 1; tick(600);

    // R2: external low on the hard line for three cycles
    tag = "R2"; hard_pad = 0; tick(3); hard_pad = 1; tick(600);

    // R4: external low on the soft line
    tag = "R4"; soft_pad = 0; tick(2); soft_pad = 1; tick(600);

    // R5: watchdog during soft assertion upgrades to hard
    tag = "R5"; test_req = 1; tick(100); wdog = 1; tick(600);

    // R6: requests during hard assertion have no effect
    tag = "R6"; wdog = 1; tick(50);
    test_req = 1; soft_pad = 0; tick(3); soft_pad = 1;
    busmon = 1; hard_pad = 0; tick(2); hard_pad = 1; tick(600);

    // R7: hard line held low externally past the interval extends the wait
    tag = "R7"; wdog = 1; tick(200); hard_pad = 0; tick(400); hard_pad = 1; tick(100);

    // R8: external low and watchdog during blanking are ignored
    tag = "R8"; wdog = 1; tick(520); soft_pad = 0; tick(3); soft_pad = 1; tick(3);
    wdog = 1; tick(40);

    // R6: requests during soft release wait ignored
    tag = "R6"; test_req = 1; tick(514); test_req = 1; tick(1); tick(60);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule